// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block keeps a free-running microsecond count for a chip whose reference clock is not a whole multiple of 1 MHz. A fractional rate generator running on the reference clock produces N microsecond ticks for every M reference clocks. Each tick advances an up-counter by one. Software sets N and M through one 16-bit configuration word. Both fields are stored minus one. A reference of 12.8 MHz therefore takes N=5 and M=64, written as 0x043F. Integer ratios such as 12 MHz (0x000B) or 48 MHz (0x002F) leave the upper byte at zero.

Ticks are spread evenly over the M-clock window by a remainder accumulator, so the rate is exact on average. A freeze control stops both the counter and the accumulator. A single-cycle register port gives access to the counter, the configuration and the freeze control. The counter is read-only.

Top module: `frac_usec_counter`

## Requirements
- R1: After synchronous reset, the counter reads 0, the configuration reads 0x000B, and the freeze control reads 0.
- R2: For configuration word W, bits [15:8] give N-1 and bits [7:0] give M-1. Starting from a cleared accumulator, exactly N ticks occur over any M consecutive running clocks. Examples: 0x043F gives 5 ticks in 64 clocks, and 0x002F gives 1 tick in 48 clocks.
- R3: Each clock adds N to the accumulator. A tick occurs on the first clock where the running sum reaches M or more, and M is then subtracted. The counter never advances by more than one per clock. When N exceeds M, the counter advances on every clock.
- R4: Register reads are combinational. Offset 0x10 returns the counter, zero-extended. Offset 0x14 returns the configuration in bits [15:0] with zeros above. Offset 0x4C returns the freeze bit in bit 0. Every other offset reads 0.
- R5: While freeze bit 0 is 1, the counter and the accumulator hold their values. Clearing the bit resumes counting from the held accumulator value. Only bit 0 of a freeze write is stored.
- R6: A write to the configuration clears the accumulator, and no tick occurs in the cycle of the write. Counting uses the new ratio from the next clock onward.
- R7: A write to the counter offset, or to an unmapped offset, changes nothing.
- R8: The counter is COUNT_W bits wide (32 by default) and wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe, one cycle |
| addr | input | ADDR_W (8) | Register byte offset |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Combinational read data for addr |

## Verification
The ratio logic is driven with four kinds of configuration word, and each kind separates a different fault:
- A fractional word (0x043F) checks both the tick total over a full window and the clock of the first tick (clock 13), so an error in the remainder handling shows up.
- Integer words (0x002F and the reset value 0x000B) check the bias-by-one in the low field.
- A word whose upper byte exceeds the lower byte checks the one-tick-per-clock cap.
- A word of zero drives the narrow counter through its wrap.

A behavioural model runs alongside these tests and is compared with the read port on every clock. This comparison covers:
- freezing and unfreezing in the middle of an accumulation;
- rewriting the configuration in the middle of an accumulation, to confirm that the accumulator is cleared;
- writes to offsets that must be ignored.

// File: rtl/frac_usec_pkg.sv
package frac_usec_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;

  typedef struct packed {
    logic               clearAcc;
    logic               runEn;
    logic [FIELD_W-1:0] numM1;
    logic [FIELD_W-1:0] denM1;
  } tickCtl_t;
endpackage

// File: rtl/frac_usec_ctrl.sv
module frac_usec_ctrl
  import frac_usec_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int COUNT_W = 32,
  parameter logic [ADDR_W-1:0] OFF_CNT = 8'h10,
  parameter logic [ADDR_W-1:0] OFF_CFG = 8'h14,
  parameter logic [ADDR_W-1:0] OFF_FRZ = 8'h4C,
  parameter logic [CFG_W-1:0]  CFG_RESET = 16'h000B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [COUNT_W-1:0] countVal,
  output tickCtl_t           ctl,
  output logic [DATA_W-1:0]  rdData
);
  logic [CFG_W-1:0] cfgReg;
  logic             frozen;
  logic             wrCfg;
  logic             wrFrz;
  logic             unusedWrBits;

  assign wrCfg = wrEn && (addr == OFF_CFG);
  assign wrFrz = wrEn && (addr == OFF_FRZ);
  assign unusedWrBits = ^wrData[DATA_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg <= CFG_RESET;
      frozen <= 1'b0;
    end else begin
      if (wrCfg) cfgReg <= wrData[CFG_W-1:0];
      if (wrFrz) frozen <= wrData[0];
    end
  end

  always_comb begin
    ctl.clearAcc = wrCfg;
    ctl.runEn    = !frozen && !wrCfg;
    ctl.numM1    = cfgReg[CFG_W-1:FIELD_W];
    ctl.denM1    = cfgReg[FIELD_W-1:0];
  end

  always_comb begin
    rdData = '0;
    if (addr == OFF_CNT)      rdData[COUNT_W-1:0] = countVal;
    else if (addr == OFF_CFG) rdData[CFG_W-1:0]   = cfgReg;
    else if (addr == OFF_FRZ) rdData[0]           = frozen;
  end

  // R6: configuration changes only on a write to its offset
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(wrCfg) |-> $stable(cfgReg));

  // R5: freeze bit changes only on a write to its offset
  p_frz_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(wrFrz) |-> $stable(frozen));
endmodule

// File: rtl/frac_usec_dp.sv
module frac_usec_dp
  import frac_usec_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  tickCtl_t           ctl,
  output logic [COUNT_W-1:0] countVal
);
  localparam int ACC_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] inc;
  logic [ACC_W-1:0] div;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] rem;
  logic [ACC_W-1:0] accNext;
  logic             tickNow;

  always_comb begin
    inc     = {2'b00, ctl.numM1} + ACC_W'(1);
    div     = {2'b00, ctl.denM1} + ACC_W'(1);
    sum     = acc + inc;
    rem     = sum - div;
    tickNow = ctl.runEn && (sum >= div);
    if (sum >= div) accNext = (rem >= div) ? {2'b00, ctl.denM1} : rem;
    else            accNext = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      countVal <= '0;
    end else if (ctl.clearAcc) begin
      acc <= '0;
    end else if (ctl.runEn) begin
      acc <= accNext;
      if (tickNow) countVal <= countVal + COUNT_W'(1);
    end
  end

  // R3: remainder stays below the divisor
  p_acc_below_div_r3: assert property (@(posedge clk) disable iff (rst)
    acc <= {2'b00, ctl.denM1});

  // R3: counter advances by at most one per clock
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (countVal == $past(countVal)) || (countVal == $past(countVal) + COUNT_W'(1)));

  // R5: nothing moves while not running
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(ctl.runEn) |-> $stable(countVal));

  // R6: configuration write leaves the accumulator empty
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(ctl.clearAcc) |-> (acc == '0));
endmodule

// File: rtl/frac_usec_counter.sv
module frac_usec_counter
  import frac_usec_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  tickCtl_t           ctl;
  logic [COUNT_W-1:0] countVal;

  frac_usec_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .countVal(countVal), .ctl(ctl), .rdData(rdData)
  );

  frac_usec_dp #(.COUNT_W(COUNT_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .countVal(countVal)
  );
endmodule

// File: tb/frac_usec_counter_test.sv
module frac_usec_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int CMASK = (1 << CW) - 1;
  localparam logic [7:0] A_CNT = 8'h10, A_CFG = 8'h14, A_FRZ = 8'h4C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = A_CNT;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit modelOn = 0;
  bit done = 0;

  int mCount, mCfg, mAcc, mFrz;

  frac_usec_counter #(.COUNT_W(CW)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      mCount = 0; mCfg = 'h000B; mAcc = 0; mFrz = 0;
    end else begin
      int n, m, s;
      bit wc, wf;
      n = ((mCfg >> 8) & 255) + 1;
      m = (mCfg & 255) + 1;
      wc = wrEn && addr == A_CFG;
      wf = wrEn && addr == A_FRZ;
      if (wc) mAcc = 0;
      else if (!mFrz) begin
        s = mAcc + n;
        if (s >= m) begin
          mCount = (mCount + 1) & CMASK;
          mAcc = (s - m >= m) ? m - 1 : s - m;
        end else mAcc = s;
      end
      if (wc) mCfg = wrData & 'hFFFF;
      if (wf) mFrz = wrData[0];
    end
  end

  function automatic int expRead(logic [7:0] a);
    if (a == A_CNT) return mCount;
    if (a == A_CFG) return mCfg;
    if (a == A_FRZ) return mFrz;
    return 0;
  endfunction

  task automatic checkEq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (modelOn) checkEq("R2 R3 per-clock model", int'(rdData), expRead(addr));

  task automatic step(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step(1);
    wrEn = 1'b0; addr = A_CNT;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    addr = a; #1; v = int'(rdData); addr = A_CNT; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, c0;
    step(3);
    rst = 1'b0;
    modelOn = 1;
    // R1 reset state
    rd(A_CNT, v); checkEq("R1 count", v, 0);
    rd(A_CFG, v); checkEq("R1 config", v, 'h000B);
    rd(A_FRZ, v); checkEq("R1 freeze", v, 0);
    // R2 reset ratio: 12 clocks per tick
    step(11); rd(A_CNT, v); checkEq("R2 default 11 clocks", v, 0);
    step(1);  rd(A_CNT, v); checkEq("R2 default 12 clocks", v, 1);
    // R6 mid-accumulation rewrite
    step(11);
    wr(A_CFG, 32'h000B);
    rd(A_CNT, c0); checkEq("R6 no tick on write", c0, 1);
    step(11); rd(A_CNT, v); checkEq("R6 cleared acc 11", v, c0);
    step(1);  rd(A_CNT, v); checkEq("R6 cleared acc 12", v, c0 + 1);
    // R3 first fractional tick on clock 13
    wr(A_CFG, 32'h043F);
    rd(A_CNT, c0);
    step(12); rd(A_CNT, v); checkEq("R3 before first tick", v, c0);
    step(1);  rd(A_CNT, v); checkEq("R3 first tick", v, c0 + 1);
    // R2 five ticks in 64 clocks
    wr(A_CFG, 32'h043F);
    rd(A_CNT, c0);
    step(64); rd(A_CNT, v); checkEq("R2 0x043F window", v, c0 + 5);
    rd(A_CFG, v); checkEq("R4 config read", v, 'h043F);
    // R2 integer 48
    wr(A_CFG, 32'hFFFF002F);
    rd(A_CFG, v); checkEq("R2 upper data bits dropped", v, 'h002F);
    rd(A_CNT, c0);
    step(47); rd(A_CNT, v); checkEq("R2 0x002F 47", v, c0);
    step(1);  rd(A_CNT, v); checkEq("R2 0x002F 48", v, c0 + 1);
    // R3 cap: N > M
    wr(A_CFG, 32'h0500);
    rd(A_CNT, c0);
    step(7); rd(A_CNT, v); checkEq("R3 cap one per clock", v, (c0 + 7) & CMASK);
    // R5 freeze mid-accumulation
    wr(A_CFG, 32'h043F);
    step(20);
    wr(A_FRZ, 32'h3);
    rd(A_FRZ, v); checkEq("R5 freeze reads bit0", v, 1);
    rd(A_CNT, c0);
    step(40); rd(A_CNT, v); checkEq("R5 frozen hold", v, c0);
    // R7 ignored writes
    wr(A_CNT, 32'h5A);
    rd(A_CNT, v); checkEq("R7 counter write ignored", v, c0);
    wr(8'h20, 32'h1234);
    rd(8'h20, v); checkEq("R4 unmapped reads zero", v, 0);
    rd(A_CFG, v); checkEq("R7 unmapped write no effect", v, 'h043F);
    wr(A_FRZ, 32'hFFFFFFFE);
    rd(A_FRZ, v); checkEq("R5 unfreeze", v, 0);
    step(44);
    // R8 wrap
    wr(A_CFG, 32'h0000);
    rd(A_CNT, c0);
    step(CMASK - c0); rd(A_CNT, v); checkEq("R8 all ones", v, CMASK);
    step(1); rd(A_CNT, v); checkEq("R8 wrap to zero", v, 0);
    step(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule